// File: doc/BRIEF.md
# Per-Component Video Frame CRC Calculator

This block watches a video pixel stream and builds one 16-bit CRC for each of the three colour components of every frame. Pixels arrive on a stream interface with `tvalid`, `tready` and `tlast` (end of line). A beat carries either one or two pixels. A separate vertical sync input marks frame boundaries. Each component has its own CRC engine. On every accepted beat, an engine combines its own value from the previous cycle with the new samples. The generator polynomial is x^16 + x^15 + x^2 + 1 (0x8005). Bits are fed most significant first and the engine starts from zero.

On the rising edge of vertical sync, the three engine values become the results for the frame that just ended. They appear on three outputs together with a one-cycle valid pulse and stay unchanged until the next sync. The first accepted beat after sync starts the new frame from a zero seed.

In YCbCr 4:2:2 at one pixel per clock, a single chroma field carries Cb and Cr on alternating beats. The block steers that field to the Cb engine on one beat and to the Cr engine on the next. The Cb/Cr phase restarts at the start of every line.

A two-state controller tracks the frame:
- `ST_WAIT_FIRST` waits for the first beat of a frame. The transition FIRST_BEAT, taken on an accepted beat, moves it to `ST_IN_FRAME` and clears the engines.
- `ST_IN_FRAME` accumulates. The transition FRAME_END, taken on a sync rise with no beat in the same cycle, returns it to `ST_WAIT_FIRST`.
- The transition RESTART (a sync rise together with a beat) stays in `ST_IN_FRAME` and makes that beat the first beat of the new frame.

Top module: `vid_frame_crc`

## Requirements
- R1: During and right after reset, `crc_valid_o` is 0 and all three CRC outputs are 0.
- R2: In RGB mode at one pixel per clock, each beat carries one pixel. Lane k sits in `s_tdata[16k+15:16k]`, and lanes 0, 1 and 2 go to `crc0_o`, `crc1_o` and `crc2_o`. Each result is the MSB-first CRC (polynomial 0x8005, seed 0) of that lane's samples in arrival order. A single sample of 0x0001 gives 0x8005.
- R3: In two-pixel mode (`ppc2_i`=1), the first pixel occupies bits 47:0 and the second occupies bits 95:48, with the same lane order as R2. Each engine folds the first pixel's sample and then the second pixel's sample in one beat.
- R4: In 4:2:2 mode (`ycc422_i`=1) at one pixel per clock, lane 0 is Y and goes to `crc0_o`. Lane 1 is chroma and goes to the Cb result `crc1_o` on even beats of a line (counting from 0) and to the Cr result `crc2_o` on odd beats. Lane 2 is ignored.
- R5: The Cb/Cr phase restarts on the beat after a beat with `s_tlast`=1 and on the first beat of a frame, so every line starts with Cb.
- R6: In 4:2:2 two-pixel mode, both Y samples are folded into `crc0_o`, first pixel first. The first pixel's lane 1 goes to Cb (`crc1_o`) and the second pixel's lane 1 goes to Cr (`crc2_o`).
- R7: A beat with `s_tvalid` or `s_tready` low changes no CRC.
- R8: On a rising edge of `vsync_i`, the engine values before that cycle's beat appear on the outputs one cycle later, with `crc_valid_o` high for exactly one cycle. The outputs then hold until the next rising edge.
- R9: Each frame's CRCs start from a zero seed at the first accepted beat after a sync rise, whatever the previous frame held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync; its rising edge closes a frame |
| ppc2_i | input | 1 | 1 = two pixels per beat |
| ycc422_i | input | 1 | 1 = YCbCr 4:2:2, 0 = three full components |
| s_tvalid | input | 1 | Stream valid |
| s_tready | input | 1 | Stream ready (observed, not driven) |
| s_tlast | input | 1 | Last beat of a line |
| s_tdata | input | 6*COMP_W | Two pixels of three lanes each |
| crc0_o | output | 16 | Frame CRC of R or Y |
| crc1_o | output | 16 | Frame CRC of G or Cb |
| crc2_o | output | 16 | Frame CRC of B or Cr |
| crc_valid_o | output | 1 | One-cycle pulse when new results are presented |

## Verification
The bench targets the 4:2:2 chroma steering with lines of odd length. A design that lets the Cb/Cr phase run on across `tlast` would swap the chroma samples between the two engines on the next line, so both chroma results would be wrong. Stalled beats carry garbage data, so a design that ignores `tready` would pull that garbage into every CRC. Back-to-back frames with different contents expose a design that fails to reseed to zero, and two-pixel beats expose folding the pixels in the wrong order. After each sync the bench checks that the valid pulse is one cycle long and that the results stay unchanged afterwards.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
    localparam int CRC_W = 16;
    localparam int NUM_COMP = 3;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

    typedef enum logic [0:0] {
        ST_WAIT_FIRST = 1'b0,
        ST_IN_FRAME   = 1'b1
    } vfc_state_e;

    // One 16-bit word folded into the CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] seed,
                                                  input logic [CRC_W-1:0] word);
        logic [CRC_W-1:0] acc;
        logic fb;
        acc = seed;
        for (int i = CRC_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ word[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return acc;
    endfunction
endpackage

// File: rtl/vfc_crc_engine.sv
module vfc_crc_engine
    import vfc_pkg::*;
#(
    parameter int COMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              two_step,
    input  logic [COMP_W-1:0] samp_a,
    input  logic [COMP_W-1:0] samp_b,
    output logic [CRC_W-1:0]  crc_q
);
    localparam int PAD_W = CRC_W - COMP_W;

    logic [CRC_W-1:0] word_a, word_b;
    logic [CRC_W-1:0] seed, step1, step2;

    generate
        if (PAD_W == 0) begin : g_full
            assign word_a = samp_a;
            assign word_b = samp_b;
        end else begin : g_pad
            assign word_a = {samp_a, {PAD_W{1'b0}}};
            assign word_b = {samp_b, {PAD_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        seed  = clr ? '0 : crc_q;
        step1 = crc_fold(seed, word_a);
        step2 = two_step ? crc_fold(step1, word_b) : step1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= step2;
        end else if (clr) begin
            crc_q <= '0;
        end
    end
endmodule

// File: rtl/vfc_lane_steer.sv
module vfc_lane_steer
    import vfc_pkg::*;
#(
    parameter int COMP_W = 16
) (
    input  logic [2*NUM_COMP*COMP_W-1:0]    tdata,
    input  logic                            beat,
    input  logic                            ycc422,
    input  logic                            ppc2,
    input  logic                            chroma_ph,
    output logic [NUM_COMP-1:0]             eng_en,
    output logic [NUM_COMP-1:0]             eng_two,
    output logic [NUM_COMP-1:0][COMP_W-1:0] eng_a,
    output logic [NUM_COMP-1:0][COMP_W-1:0] eng_b
);
    localparam int LANES = 2 * NUM_COMP;

    logic [LANES-1:0][COMP_W-1:0] lane;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_slice
            assign lane[g] = tdata[g*COMP_W +: COMP_W];
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < NUM_COMP; k++) begin
            eng_en[k]  = beat;
            eng_two[k] = ppc2;
            eng_a[k]   = lane[k];
            eng_b[k]   = lane[NUM_COMP + k];
        end
        if (ycc422) begin
            if (ppc2) begin
                eng_two[1] = 1'b0;
                eng_two[2] = 1'b0;
                eng_a[1]   = lane[1];
                eng_a[2]   = lane[NUM_COMP + 1];
            end else begin
                eng_en[1] = beat & ~chroma_ph;
                eng_en[2] = beat & chroma_ph;
                eng_a[1]  = lane[1];
                eng_a[2]  = lane[1];
            end
        end
    end
endmodule

// File: rtl/vfc_frame_ctrl.sv
module vfc_frame_ctrl
    import vfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic beat,
    input  logic tlast,
    output logic vsync_rise,
    output logic frame_clr,
    output logic chroma_ph
);
    vfc_state_e state_q, state_d;
    logic vsync_q;
    logic line_first_q;
    logic ph_q;

    assign vsync_rise = vsync_i & ~vsync_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: FIRST_BEAT, FRAME_END, RESTART.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_FIRST: if (beat) state_d = ST_IN_FRAME;
            ST_IN_FRAME:   if (vsync_rise && !beat) state_d = ST_WAIT_FIRST;
            default:       state_d = ST_WAIT_FIRST;
        endcase
    end

    // Outputs of the controller.
    always_comb begin
        frame_clr = beat && ((state_q == ST_WAIT_FIRST) || vsync_rise);
        chroma_ph = (line_first_q || frame_clr) ? 1'b0 : ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsync_q      <= 1'b0;
            line_first_q <= 1'b1;
            ph_q         <= 1'b0;
        end else begin
            vsync_q <= vsync_i;
            if (beat) begin
                line_first_q <= tlast;
                ph_q         <= ~chroma_ph;
            end else if (vsync_rise) begin
                line_first_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vid_frame_crc.sv
module vid_frame_crc
    import vfc_pkg::*;
#(
    parameter int COMP_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vsync_i,
    input  logic                       ppc2_i,
    input  logic                       ycc422_i,
    input  logic                       s_tvalid,
    input  logic                       s_tready,
    input  logic                       s_tlast,
    input  logic [2*NUM_COMP*COMP_W-1:0] s_tdata,
    output logic [CRC_W-1:0]           crc0_o,
    output logic [CRC_W-1:0]           crc1_o,
    output logic [CRC_W-1:0]           crc2_o,
    output logic                       crc_valid_o
);
    logic beat, vsync_rise, frame_clr, chroma_ph;
    logic [NUM_COMP-1:0] eng_en, eng_two;
    logic [NUM_COMP-1:0][COMP_W-1:0] eng_a, eng_b;
    logic [NUM_COMP-1:0][CRC_W-1:0] eng_q;

    assign beat = s_tvalid & s_tready;

    vfc_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_i   (vsync_i),
        .beat      (beat),
        .tlast     (s_tlast),
        .vsync_rise(vsync_rise),
        .frame_clr (frame_clr),
        .chroma_ph (chroma_ph)
    );

    vfc_lane_steer #(.COMP_W(COMP_W)) u_steer (
        .tdata    (s_tdata),
        .beat     (beat),
        .ycc422   (ycc422_i),
        .ppc2     (ppc2_i),
        .chroma_ph(chroma_ph),
        .eng_en   (eng_en),
        .eng_two  (eng_two),
        .eng_a    (eng_a),
        .eng_b    (eng_b)
    );

    generate
        for (genvar k = 0; k < NUM_COMP; k++) begin : g_eng
            vfc_crc_engine #(.COMP_W(COMP_W)) u_eng (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (frame_clr),
                .en      (eng_en[k]),
                .two_step(eng_two[k]),
                .samp_a  (eng_a[k]),
                .samp_b  (eng_b[k]),
                .crc_q   (eng_q[k])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc0_o      <= '0;
            crc1_o      <= '0;
            crc2_o      <= '0;
            crc_valid_o <= 1'b0;
        end else begin
            crc_valid_o <= vsync_rise;
            if (vsync_rise) begin
                crc0_o <= eng_q[0];
                crc1_o <= eng_q[1];
                crc2_o <= eng_q[2];
            end
        end
    end
endmodule

// File: rtl/vfc_frame_crc_chk.sv
module vfc_frame_crc_chk
    import vfc_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          vsync_i,
    input logic                          s_tvalid,
    input logic                          s_tready,
    input logic [CRC_W-1:0]              crc0_o,
    input logic [CRC_W-1:0]              crc1_o,
    input logic [CRC_W-1:0]              crc2_o,
    input logic                          crc_valid_o,
    input logic [NUM_COMP-1:0][CRC_W-1:0] eng_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!crc_valid_o && crc0_o == '0 && crc1_o == '0 && crc2_o == '0));

    // R8
    valid_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_i) |=> crc_valid_o);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid_o |=> !crc_valid_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_valid_o |-> ($stable(crc0_o) && $stable(crc1_o) && $stable(crc2_o)));

    // R7
    idle_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tvalid && s_tready) |=> $stable(eng_q));
endmodule

bind vid_frame_crc vfc_frame_crc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_i    (vsync_i),
    .s_tvalid   (s_tvalid),
    .s_tready   (s_tready),
    .crc0_o     (crc0_o),
    .crc1_o     (crc1_o),
    .crc2_o     (crc2_o),
    .crc_valid_o(crc_valid_o),
    .eng_q      (eng_q)
);

// File: tb/vid_frame_crc_tb_top.sv
module vid_frame_crc_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_i = 1'b0;
    logic ppc2_i = 1'b0;
    logic ycc422_i = 1'b0;
    logic s_tvalid = 1'b0;
    logic s_tready = 1'b0;
    logic s_tlast = 1'b0;
    logic [95:0] s_tdata = '0;
    logic [15:0] crc0_o, crc1_o, crc2_o;
    logic crc_valid_o;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] m [3];
    int line_pos = 0;

    always #5 clk = ~clk;

    vid_frame_crc dut_i (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .ppc2_i(ppc2_i),
        .ycc422_i(ycc422_i), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_tdata(s_tdata), .crc0_o(crc0_o),
        .crc1_o(crc1_o), .crc2_o(crc2_o), .crc_valid_o(crc_valid_o)
    );

    // Polynomial division of the running remainder by 0x8005, MSB first.
    function automatic logic [15:0] ref_crc(input logic [15:0] r, input logic [15:0] w);
        logic [15:0] x = r;
        for (int b = 15; b >= 0; b--) begin
            if (x[15] != w[b]) x = (x << 1) ^ 16'h8005;
            else               x = x << 1;
        end
        return x;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ln(input logic [95:0] d, input int idx);
        return d[idx*16 +: 16];
    endfunction

    task automatic beat(input logic [95:0] d, input logic last, input logic v, input logic r);
        @(negedge clk);
        s_tdata = d; s_tlast = last; s_tvalid = v; s_tready = r;
        if (v && r) begin
            if (!ycc422_i && !ppc2_i) begin
                for (int k = 0; k < 3; k++) m[k] = ref_crc(m[k], ln(d, k));
            end else if (!ycc422_i) begin
                for (int k = 0; k < 3; k++) m[k] = ref_crc(ref_crc(m[k], ln(d, k)), ln(d, k + 3));
            end else if (ppc2_i) begin
                m[0] = ref_crc(ref_crc(m[0], ln(d, 0)), ln(d, 3));
                m[1] = ref_crc(m[1], ln(d, 1));
                m[2] = ref_crc(m[2], ln(d, 4));
            end else begin
                m[0] = ref_crc(m[0], ln(d, 0));
                if (line_pos % 2 == 0) m[1] = ref_crc(m[1], ln(d, 1));
                else                   m[2] = ref_crc(m[2], ln(d, 1));
            end
            line_pos = last ? 0 : line_pos + 1;
        end
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        s_tvalid = 0; s_tready = 0; s_tlast = 0; vsync_i = 1;
        @(negedge clk);
        vsync_i = 0;
    endtask

    task automatic start_frame(input logic yc, input logic p2);
        @(negedge clk);
        ycc422_i = yc; ppc2_i = p2;
        sync_pulse();
        for (int k = 0; k < 3; k++) m[k] = '0;
        line_pos = 0;
    endtask

    task automatic end_frame(input string req);
        logic [15:0] h0, h1, h2;
        sync_pulse();
        chk({req, " valid pulse"}, {15'd0, crc_valid_o}, 16'd1);
        chk({req, " crc0"}, crc0_o, m[0]);
        chk({req, " crc1"}, crc1_o, m[1]);
        chk({req, " crc2"}, crc2_o, m[2]);
        h0 = crc0_o; h1 = crc1_o; h2 = crc2_o;
        repeat (2) @(negedge clk);
        chk("R8 valid drops", {15'd0, crc_valid_o}, 16'd0);
        chk("R8 results held", crc0_o ^ crc1_o ^ crc2_o, h0 ^ h1 ^ h2);
    endtask

    function automatic logic [95:0] pat(input int seed);
        logic [95:0] d;
        for (int k = 0; k < 6; k++) d[k*16 +: 16] = 16'(seed * 16'h2f1b + k * 16'h1357 + 16'h00a5);
        return d;
    endfunction

    task automatic t_reset();
        chk("R1 valid in reset", {15'd0, crc_valid_o}, 16'd0);
        chk("R1 crc0 in reset", crc0_o, 16'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 crc1 after reset", crc1_o, 16'd0);
        chk("R1 crc2 after reset", crc2_o, 16'd0);
    endtask

    task automatic t_known_value();
        start_frame(0, 0);
        beat(96'h0001, 0, 1, 1);
        sync_pulse();
        chk("R2 single word 0x0001", crc0_o, 16'h8005);
    endtask

    task automatic t_rgb_1ppc();
        start_frame(0, 0);
        for (int i = 0; i < 9; i++) beat(pat(i), (i % 3) == 2, 1, 1);
        end_frame("R2 rgb 1ppc");
    endtask

    task automatic t_rgb_2ppc();
        start_frame(0, 1);
        for (int i = 0; i < 7; i++) beat(pat(i + 40), (i % 4) == 3, 1, 1);
        end_frame("R3 rgb 2ppc");
    endtask

    task automatic t_ycc_1ppc();
        start_frame(1, 0);
        for (int i = 0; i < 8; i++) beat(pat(i + 90), 0, 1, 1);
        end_frame("R4 422 1ppc");
    endtask

    task automatic t_line_restart();
        start_frame(1, 0);
        for (int i = 0; i < 9; i++) beat(pat(i + 130), (i % 3) == 2, 1, 1);
        end_frame("R5 line phase restart");
    endtask

    task automatic t_ycc_2ppc();
        start_frame(1, 1);
        for (int i = 0; i < 6; i++) beat(pat(i + 170), (i % 3) == 2, 1, 1);
        end_frame("R6 422 2ppc");
    endtask

    task automatic t_stall();
        start_frame(0, 0);
        for (int i = 0; i < 5; i++) begin
            beat(pat(i + 200), 0, 1, 1);
            beat(pat(i + 300), 0, 1, 0);
            beat(pat(i + 400), 0, 0, 1);
        end
        end_frame("R7 stalled beats");
    endtask

    task automatic t_reseed();
        start_frame(0, 0);
        for (int i = 0; i < 4; i++) beat(pat(i + 500), 0, 1, 1);
        end_frame("R9 frame A");
        for (int k = 0; k < 3; k++) m[k] = '0;
        line_pos = 0;
        for (int i = 0; i < 3; i++) beat(pat(i + 600), 0, 1, 1);
        end_frame("R9 frame B from zero");
    endtask

    initial begin
        t_reset();
        t_known_value();
        t_rgb_1ppc();
        t_rgb_2ppc();
        t_ycc_1ppc();
        t_line_restart();
        t_ycc_2ppc();
        t_stall();
        t_reseed();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule